// File: doc/BRIEF.md
# Read Latency Sweep Trainer

This block is a hardware training engine that finds, for each of two memory channels, the smallest read-latency setting at which a known data pattern reads back intact. For each channel being trained, it first stores a fixed 48-word pattern at the channel's test address. It then tries latency values one after another, starting from a supplied start value. For each value it programs the channel's latency register, reads the pattern back and compares it word by word. At the first value that reads back cleanly it stops. It then writes the final setting, which is that value plus a supplied safety margin.

The block is started with a single pulse. It trains channel 0 and then channel 1, and pulses its done output once both have been handled. A channel is skipped when its test address is flagged invalid. Channel 1 is also skipped in ganged mode, where one result serves both channels. Memory is reached through a request port with a valid/ready handshake and a response port that carries a valid strobe. The channel latency registers are written through a simple write port, and the block also keeps its own stored copy of each channel's value.

Top module: `rdlat_sweep_trainer`

## Requirements
- R1: After reset, `doneOut`, `memReqValid` and `latWrEn` are low, and `chLat0`, `chLat1` and `chFail` read zero.
- R2: For each channel being trained, the block writes 48 words to consecutive 4-byte addresses starting at that channel's test address. All 48 writes happen before the first latency write for that channel. Word k is computed as follows, with all arithmetic modulo 2^32: a = (k+1)·0x9E3779B1; b = a xor (a>>16); c = b·0x85EBCA6B; word = c xor (c>>13).
- R3: The first latency programmed for a channel is `startLat`. Each failed attempt raises the latency by exactly one. An attempt is made only while the latency is below MAX_LAT (default 40). Every attempt writes its latency through the write port before any of its reads.
- R4: Within an attempt, reads start at word 0 and climb in 4-byte steps from the test address.
- R5: An attempt ends at the first mismatching word, so that word's read is the attempt's last read. A passing attempt reads all 48 words.
- R6: On a pass, the final write carries the passing latency plus `marginLat`, saturated at 2^LAT_W−1 (1023 by default).
- R7: If no attempt passes, the final write carries the latency at which the sweep stopped plus the margin. That latency is MAX_LAT, or `startLat` if `startLat` was already at or above MAX_LAT. The channel's `chFail` bit is then set and stays set until reset.
- R8: Channels are trained in the order 0 then 1. In ganged mode, channel 1 is never accessed. Every latency write goes out with `latWrCh`=0 and updates both `chLat0` and `chLat1`, and a failure sets both `chFail` bits.
- R9: A channel whose `chValid` bit is low gets no memory access and no latency write. Its stored value stays unchanged.
- R10: Read data is taken only when `memRspValid` is high while a read is outstanding. Results do not depend on response delay, on `memReqReady` stalls, or on response strobes that arrive with no read outstanding. A request is held steady while it is not accepted.
- R11: `doneOut` is high for exactly one cycle after the last channel has been handled, including when both channels are skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, taken when idle |
| gangedMode | input | 1 | Both channels share one result; channel 1 skipped |
| chValid | input | 2 | Per-channel test-address valid flags |
| testAddr0 | input | ADDR_W | Channel 0 test address |
| testAddr1 | input | ADDR_W | Channel 1 test address |
| startLat | input | LAT_W | First latency value tried |
| marginLat | input | LAT_W | Margin added to the final value |
| doneOut | output | 1 | One-cycle completion pulse |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqAddr | output | ADDR_W | Byte address of the request |
| memReqWdata | output | 32 | Write data |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data |
| latWrEn | output | 1 | Latency register write strobe |
| latWrCh | output | 1 | Channel index of the latency write |
| latWrVal | output | LAT_W | Latency value written |
| chLat0 | output | LAT_W | Stored latency of channel 0 |
| chLat1 | output | LAT_W | Stored latency of channel 1 |
| chFail | output | 2 | Sticky no-pass flags, bit n for channel n |

## Verification
The bench's memory model corrupts one chosen word whenever the latency last programmed for a channel is below a hidden pass point. A design that fails to abort early, reads out of order, or starts from the wrong value then shows up as a wrong read count or an address-order error. The corner cases are:
- A pass on the very first attempt, where an off-by-one in the sweep commits one step late.
- Corruption on the last word, which catches a compare that stops at 47 words.
- No pass before the limit, and a start value already past the limit, where a design that never sets the sticky flag, or that still reads, is caught.
- A margin that overflows, which a non-saturating adder wraps to a small value.
- Ganged runs, where one stored value left stale or an access to channel 1 gives itself away.
- Slow and stalled responses, and spurious response strobes, which a design that samples data without the valid strobe would misread.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;

  localparam int NUM_WORDS = 48;
  localparam int DATA_W    = 32;

  // Fixed training word k, generated by a mixing hash of the index.
  function automatic logic [DATA_W-1:0] patWord(input int k);
    logic [DATA_W-1:0] x;
    x = DATA_W'(k + 1) * 32'h9E37_79B1;
    x = x ^ (x >> 16);
    x = x * 32'h85EB_CA6B;
    x = x ^ (x >> 13);
    return x;
  endfunction

  // Strobes from the controller to the datapath.
  typedef struct packed {
    logic loadCh;     // capture the selected channel's test address
    logic loadStart;  // load the sweep start value
    logic incLat;     // step the latency by one
    logic clrIdx;     // restart the word index
    logic incIdx;     // advance the word index
    logic selCommit;  // write port carries latency plus margin
    logic latWr;      // latency write strobe
    logic setFail;    // mark the channel as failed
  } dpCtl_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHK, ST_WRITE, ST_PROBE, ST_READ,
    ST_WAIT, ST_COMMIT, ST_NEXT, ST_DONE
  } trnState_t;

endpackage

// File: rtl/rdlat_pattern_rom.sv
module rdlat_pattern_rom
  import rdlat_pkg::*;
#(
  parameter int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] tab [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : gen_tab
    assign tab[g] = patWord(g);
  end

  assign word = (int'(idx) < NUM_WORDS) ? tab[idx] : '0;

endmodule

// File: rtl/rdlat_datapath.sv
module rdlat_datapath
  import rdlat_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LAT_W   = 10,
  parameter int MAX_LAT = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              chSel,
  input  logic              gangedMode,
  input  logic              latWrCh,
  input  logic [ADDR_W-1:0] testAddr0,
  input  logic [ADDR_W-1:0] testAddr1,
  input  logic [LAT_W-1:0]  startLat,
  input  logic [LAT_W-1:0]  marginLat,
  input  logic [DATA_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqWdata,
  output logic [LAT_W-1:0]  latWrVal,
  output logic              wordMatch,
  output logic              lastWord,
  output logic              latAtMax,
  output logic [LAT_W-1:0]  chLat0,
  output logic [LAT_W-1:0]  chLat1,
  output logic [1:0]        chFail
);

  localparam int IDX_W = $clog2(NUM_WORDS);
  localparam int SUM_W = LAT_W + 1;
  localparam logic [LAT_W-1:0] LAT_SAT = {LAT_W{1'b1}};

  logic [ADDR_W-1:0] baseAddr;
  logic [LAT_W-1:0]  curLat;
  logic [IDX_W-1:0]  wordIdx;
  logic [DATA_W-1:0] romWord;
  logic [SUM_W-1:0]  latSum;
  logic [LAT_W-1:0]  commitVal;

  rdlat_pattern_rom #(.IDX_W(IDX_W)) u_rom (
    .idx  (wordIdx),
    .word (romWord)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      curLat   <= '0;
      wordIdx  <= '0;
    end else begin
      if (ctl.loadCh)
        baseAddr <= chSel ? testAddr1 : testAddr0;
      if (ctl.loadStart)
        curLat <= startLat;
      else if (ctl.incLat)
        curLat <= curLat + 1'b1;
      if (ctl.clrIdx)
        wordIdx <= '0;
      else if (ctl.incIdx)
        wordIdx <= wordIdx + 1'b1;
    end
  end

  assign memReqAddr  = baseAddr + ADDR_W'({wordIdx, 2'b00});
  assign memReqWdata = romWord;
  assign wordMatch   = (memRspData == romWord);
  assign lastWord    = (wordIdx == IDX_W'(NUM_WORDS - 1));
  assign latAtMax    = ({1'b0, curLat} >= SUM_W'(MAX_LAT));

  assign latSum    = {1'b0, curLat} + {1'b0, marginLat};
  assign commitVal = latSum[LAT_W] ? LAT_SAT : latSum[LAT_W-1:0];
  assign latWrVal  = ctl.selCommit ? commitVal : curLat;

  // Stored per-channel results; ganged writes land in both.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chLat0 <= '0;
      chLat1 <= '0;
      chFail <= '0;
    end else if (ctl.latWr) begin
      if (gangedMode || !latWrCh) chLat0 <= latWrVal;
      if (gangedMode ||  latWrCh) chLat1 <= latWrVal;
      if (ctl.setFail) begin
        if (gangedMode || !latWrCh) chFail[0] <= 1'b1;
        if (gangedMode ||  latWrCh) chFail[1] <= 1'b1;
      end
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(wordIdx) < NUM_WORDS); // R4

  AST_PROBE_BELOW_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latWr && !ctl.selCommit) |-> ({1'b0, latWrVal} < SUM_W'(MAX_LAT))); // R3

  AST_COMMIT_NOT_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latWr && ctl.selCommit) |-> (latWrVal >= curLat)); // R6

  AST_GANGED_SAME: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latWr && gangedMode) |=> (chLat0 == chLat1)); // R8

  AST_FAIL0_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(chFail[0])); // R7

  AST_FAIL1_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(chFail[1])); // R7

endmodule

// File: rtl/rdlat_ctrl.sv
module rdlat_ctrl
  import rdlat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       gangedMode,
  input  logic [1:0] chValid,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       wordMatch,
  input  logic       lastWord,
  input  logic       latAtMax,
  output dpCtl_t     ctl,
  output logic       chSel,
  output logic       memReqValid,
  output logic       memReqWrite,
  output logic       latWrCh,
  output logic       doneOut
);

  trnState_t state, nxt;
  logic      chCur;
  logic      noPass;
  logic      skipCh;

  assign skipCh  = !chValid[chCur] || (chCur && gangedMode);
  assign chSel   = chCur;
  assign latWrCh = gangedMode ? 1'b0 : chCur;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      chCur  <= 1'b0;
      noPass <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && startReq) chCur <= 1'b0;
      if (state == ST_NEXT && !chCur)   chCur <= 1'b1;
      if (state == ST_CHK)              noPass <= 1'b0;
      if (state == ST_PROBE && latAtMax) noPass <= 1'b1;
    end
  end

  always_comb begin
    ctl         = '0;
    nxt         = state;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    doneOut     = 1'b0;
    case (state)
      ST_IDLE:
        if (startReq) nxt = ST_CHK;
      ST_CHK:
        if (skipCh) begin
          nxt = ST_NEXT;
        end else begin
          ctl.loadCh    = 1'b1;
          ctl.loadStart = 1'b1;
          ctl.clrIdx    = 1'b1;
          nxt           = ST_WRITE;
        end
      ST_WRITE: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          if (lastWord) nxt = ST_PROBE;
          else          ctl.incIdx = 1'b1;
        end
      end
      ST_PROBE: begin
        ctl.clrIdx = 1'b1;
        if (latAtMax) begin
          nxt = ST_COMMIT;
        end else begin
          ctl.latWr = 1'b1;
          nxt       = ST_READ;
        end
      end
      ST_READ: begin
        memReqValid = 1'b1;
        if (memReqReady) nxt = ST_WAIT;
      end
      ST_WAIT:
        if (memRspValid) begin
          if (!wordMatch) begin
            ctl.incLat = 1'b1;
            nxt        = ST_PROBE;
          end else if (lastWord) begin
            nxt = ST_COMMIT;
          end else begin
            ctl.incIdx = 1'b1;
            nxt        = ST_READ;
          end
        end
      ST_COMMIT: begin
        ctl.latWr     = 1'b1;
        ctl.selCommit = 1'b1;
        ctl.setFail   = noPass;
        nxt           = ST_NEXT;
      end
      ST_NEXT:
        nxt = chCur ? ST_DONE : ST_CHK;
      ST_DONE: begin
        doneOut = 1'b1;
        nxt     = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut); // R11

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqWrite))); // R10

  AST_NO_CH1_GANGED: assert property (@(posedge clk) disable iff (!rstN)
    (gangedMode && memReqValid) |-> !chSel); // R8

endmodule

// File: rtl/rdlat_sweep_trainer.sv
module rdlat_sweep_trainer
  import rdlat_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LAT_W   = 10,
  parameter int MAX_LAT = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              gangedMode,
  input  logic [1:0]        chValid,
  input  logic [ADDR_W-1:0] testAddr0,
  input  logic [ADDR_W-1:0] testAddr1,
  input  logic [LAT_W-1:0]  startLat,
  input  logic [LAT_W-1:0]  marginLat,
  output logic              doneOut,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [31:0]       memReqWdata,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic              latWrEn,
  output logic              latWrCh,
  output logic [LAT_W-1:0]  latWrVal,
  output logic [LAT_W-1:0]  chLat0,
  output logic [LAT_W-1:0]  chLat1,
  output logic [1:0]        chFail
);

  dpCtl_t ctl;
  logic   chSel;
  logic   wordMatch;
  logic   lastWord;
  logic   latAtMax;

  rdlat_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .gangedMode  (gangedMode),
    .chValid     (chValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .wordMatch   (wordMatch),
    .lastWord    (lastWord),
    .latAtMax    (latAtMax),
    .ctl         (ctl),
    .chSel       (chSel),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .latWrCh     (latWrCh),
    .doneOut     (doneOut)
  );

  rdlat_datapath #(
    .ADDR_W  (ADDR_W),
    .LAT_W   (LAT_W),
    .MAX_LAT (MAX_LAT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .chSel       (chSel),
    .gangedMode  (gangedMode),
    .latWrCh     (latWrCh),
    .testAddr0   (testAddr0),
    .testAddr1   (testAddr1),
    .startLat    (startLat),
    .marginLat   (marginLat),
    .memRspData  (memRspData),
    .memReqAddr  (memReqAddr),
    .memReqWdata (memReqWdata),
    .latWrVal    (latWrVal),
    .wordMatch   (wordMatch),
    .lastWord    (lastWord),
    .latAtMax    (latAtMax),
    .chLat0      (chLat0),
    .chLat1      (chLat1),
    .chFail      (chFail)
  );

  assign latWrEn = ctl.latWr;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr)); // R10

  AST_NO_ACCESS_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !gangedMode) |-> chValid[chSel]); // R9

endmodule

// File: tb/rdlat_sweep_trainer_bench.sv
module rdlat_sweep_trainer_bench;

  localparam int MAXL  = 40;
  localparam int NW    = 48;
  localparam int BASE0 = 'h040;
  localparam int BASE1 = 'h140;

  typedef struct packed {
    bit       g;     // ganged
    bit [1:0] v;     // channel valid
    int       st;    // start latency
    int       m;     // margin
    int       p0;    // pass point channel 0
    int       p1;    // pass point channel 1
    int       fw;    // corrupted word index
    bit       stall; // ready stalls
    int       dly;   // response delay
    bit       spur;  // spurious response strobes
    int       e0;    // expected chLat0
    int       e1;    // expected chLat1
    bit [1:0] ef;    // expected chFail
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b11,  5,    2,  8,  5,  0, 1'b0, 0, 1'b0,   10,    7, 2'b00},
    '{1'b0, 2'b11,  3,    1,  3, 12, 47, 1'b1, 2, 1'b1,    4,   13, 2'b00},
    '{1'b1, 2'b11,  6,    3,  9,  0, 10, 1'b1, 1, 1'b0,   12,   12, 2'b00},
    '{1'b0, 2'b10,  2,    2,  0,  4,  5, 1'b0, 0, 1'b1,    0,    6, 2'b00},
    '{1'b0, 2'b01, 30,    4, 50,  0, 20, 1'b0, 1, 1'b0,   44,    0, 2'b01},
    '{1'b0, 2'b00,  5,    1,  0,  0,  0, 1'b0, 0, 1'b0,    0,    0, 2'b00},
    '{1'b0, 2'b11, 38, 1000, 39, 38,  0, 1'b1, 0, 1'b0, 1023, 1023, 2'b00},
    '{1'b0, 2'b01, 45,    1,  0,  0,  0, 1'b0, 0, 1'b0,   46,    0, 2'b01},
    '{1'b1, 2'b11, 37,    0, 99,  0,  3, 1'b0, 3, 1'b1,   40,   40, 2'b11},
    '{1'b0, 2'b01,  0,    0, 39,  0, 47, 1'b1, 3, 1'b0,   39,    0, 2'b00}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        gangedMode = 1'b0;
  logic [1:0]  chValid = 2'b00;
  logic [15:0] testAddr0 = 16'(BASE0);
  logic [15:0] testAddr1 = 16'(BASE1);
  logic [9:0]  startLat = '0;
  logic [9:0]  marginLat = '0;
  logic        doneOut, memReqValid, memReqWrite, latWrEn, latWrCh;
  logic        memReqReady = 1'b0;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic [15:0] memReqAddr;
  logic [31:0] memReqWdata;
  logic [9:0]  latWrVal, chLat0, chLat1;
  logic [1:0]  chFail;

  rdlat_sweep_trainer u_rdlat_sweep_trainer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .gangedMode(gangedMode),
    .chValid(chValid), .testAddr0(testAddr0), .testAddr1(testAddr1),
    .startLat(startLat), .marginLat(marginLat), .doneOut(doneOut),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memRspValid(memRspValid),
    .memRspData(memRspData), .latWrEn(latWrEn), .latWrCh(latWrCh),
    .latWrVal(latWrVal), .chLat0(chLat0), .chLat1(chLat1), .chFail(chFail)
  );

  always #5 clk = ~clk;

  // Pattern word as given in the requirement on the stored pattern.
  function automatic logic [31:0] refPat(input int k);
    logic [31:0] a;
    a = 32'(k + 1) * 32'h9E37_79B1;
    a = a ^ (a >> 16);
    a = a * 32'h85EB_CA6B;
    return a ^ (a >> 13);
  endfunction

  function automatic int attempts(input int st, input int ps);
    if (st >= MAXL) return 0;
    if (ps <= st)   return 1;
    if (ps >= MAXL) return MAXL - st;
    return ps - st + 1;
  endfunction

  function automatic int expReads(input int st, input int ps, input int fw);
    if (st >= MAXL) return 0;
    if (ps <= st)   return NW;
    if (ps >= MAXL) return (MAXL - st) * (fw + 1);
    return (ps - st) * (fw + 1) + NW;
  endfunction

  // Memory model and monitors, all at the falling edge.
  vec_t        cur = '0;
  int          cyc = 0;
  logic [31:0] mem [256];
  int          rdCnt [2];
  int          wrCnt [2];
  int          expIdx [2];
  int          progLat [2];
  int          firstLat [2];
  bit          latSeen [2];
  int          orderErr, latWrCnt, doneCnt;
  bit          pending;
  int          pendWait;
  logic [31:0] pendData;

  always @(negedge clk) begin
    int ch, idx;
    logic [31:0] d;
    cyc++;
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int i = 0; i < 2; i++) begin
        rdCnt[i] = 0; wrCnt[i] = 0; expIdx[i] = 0; progLat[i] = 0;
        firstLat[i] = -1; latSeen[i] = 1'b0;
      end
      orderErr = 0; latWrCnt = 0; doneCnt = 0;
      pending = 1'b0; pendWait = 0;
      memRspValid = 1'b0; memReqReady = 1'b0;
    end else begin
      memRspValid = 1'b0;
      if (pending) begin
        if (pendWait == 0) begin
          memRspValid = 1'b1; memRspData = pendData; pending = 1'b0;
        end else pendWait--;
      end else if (cur.spur && cyc[0]) begin
        memRspValid = 1'b1; memRspData = 32'hA5A5_0000 ^ cyc;
      end
      memReqReady = cur.stall ? ((cyc % 3) != 0) : 1'b1;
      if (memReqValid && memReqReady) begin
        ch  = int'(memReqAddr[8]);
        idx = (int'(memReqAddr) - (ch != 0 ? BASE1 : BASE0)) >>> 2;
        if (memReqWrite) begin
          mem[memReqAddr[9:2]] = memReqWdata;
          wrCnt[ch]++;
          if (latSeen[ch]) orderErr++;
        end else begin
          rdCnt[ch]++;
          if (idx != expIdx[ch]) orderErr++;
          expIdx[ch]++;
          d = refPat(idx);
          if (progLat[ch] < (ch != 0 ? cur.p1 : cur.p0) && idx == cur.fw) d = ~d;
          pending = 1'b1; pendWait = cur.dly; pendData = d;
        end
      end
      if (latWrEn) begin
        progLat[latWrCh] = int'(latWrVal);
        latWrCnt++;
        if (!latSeen[latWrCh]) firstLat[latWrCh] = int'(latWrVal);
        latSeen[latWrCh] = 1'b1;
        expIdx[latWrCh] = 0;
      end
      if (doneOut) doneCnt++;
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runVec(input int n);
    int t0, bad, expWr;
    bit tr0, tr1;
    cur = VECS[n];
    rstN = 1'b0;
    gangedMode = cur.g; chValid = cur.v;
    startLat = 10'(cur.st); marginLat = 10'(cur.m);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    t0 = cyc;
    while (doneCnt == 0 && (cyc - t0) < 40000) @(negedge clk);
    repeat (3) @(negedge clk);
    if (doneCnt == 0) begin
      fails++; checks++;
      $display("FAIL R11 watchdog vector %0d: actual 0 expected 1 done", n);
      return;
    end
    tr0 = cur.v[0];
    tr1 = cur.v[1] && !cur.g;
    chk("R11", $sformatf("v%0d done width", n), doneCnt, 1);
    chk("R6", $sformatf("v%0d chLat0", n), int'(chLat0), cur.e0);
    chk("R8", $sformatf("v%0d chLat1", n), int'(chLat1), cur.e1);
    chk("R7", $sformatf("v%0d chFail", n), int'(chFail), int'(cur.ef));
    chk("R5", $sformatf("v%0d reads ch0", n), rdCnt[0],
        tr0 ? expReads(cur.st, cur.p0, cur.fw) : 0);
    chk("R9", $sformatf("v%0d reads ch1", n), rdCnt[1],
        tr1 ? expReads(cur.st, cur.p1, cur.fw) : 0);
    chk("R2", $sformatf("v%0d writes ch0", n), wrCnt[0], tr0 ? NW : 0);
    chk("R8", $sformatf("v%0d writes ch1", n), wrCnt[1], tr1 ? NW : 0);
    expWr = (tr0 ? attempts(cur.st, cur.p0) + 1 : 0) + (tr1 ? attempts(cur.st, cur.p1) + 1 : 0);
    chk("R3", $sformatf("v%0d latency writes", n), latWrCnt, expWr);
    chk("R4", $sformatf("v%0d order errors", n), orderErr, 0);
    if (tr0 && cur.st < MAXL) chk("R3", $sformatf("v%0d first lat ch0", n), firstLat[0], cur.st);
    if (tr1 && cur.st < MAXL) chk("R3", $sformatf("v%0d first lat ch1", n), firstLat[1], cur.st);
    bad = 0;
    for (int k = 0; k < NW; k++) begin
      if (tr0 && mem[(BASE0 >> 2) + k] != refPat(k)) bad++;
      if (tr1 && mem[(BASE1 >> 2) + k] != refPat(k)) bad++;
    end
    chk("R2", $sformatf("v%0d pattern words", n), bad, 0);
    if (cur.spur || cur.dly > 0 || cur.stall)
      chk("R10", $sformatf("v%0d result under delay/stall", n), int'(chLat0), cur.e0);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "reset doneOut", int'(doneOut), 0);
    chk("R1", "reset memReqValid", int'(memReqValid), 0);
    chk("R1", "reset latWrEn", int'(latWrEn), 0);
    chk("R1", "reset chLat0", int'(chLat0), 0);
    chk("R1", "reset chLat1", int'(chLat1), 0);
    chk("R1", "reset chFail", int'(chFail), 0);
    for (int n = 0; n < NV; n++) runVec(n);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_900_000;
    fails++; checks++;
    $display("FAIL R11 global watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule